// File: doc/BRIEF.md
# Multithreaded Context Register File

This block keeps a private set of architectural registers for each of several hardware threads and a small scheduler that decides which thread owns the pipeline in each cycle. Every read is steered to the bank of the currently active thread. The write port carries its own thread id, so a result that retires late still lands in the bank of the thread that produced it. Switching threads only changes the context pointer, so a switch costs no cycles and nothing is saved or restored.

The scheduler has two policies, chosen by a mode input. In interleaved mode it moves to another ready thread every cycle and skips threads whose stall flag is raised. In switch-on-stall mode it stays on the current thread until that thread raises its long-stall flag, for example on a miss in a second-level cache, and then moves to the next ready thread. With every thread stalled it stays put and raises an idle flag.

Top module: `ctxrf_top`

## Requirements
- R1: While reset is high and in the cycle after it, `cur_tid` is 0, `idle` is 0, and every register of every thread reads as zero until it is written.
- R2: A write with `wr_en`=1 stores `wr_data` into register `wr_addr` of thread `wr_tid`, whichever thread is active. The physical entry is `wr_tid*NREG + wr_addr`.
- R3: Both read ports return, one clock after the address is presented, the register of the thread that `cur_tid` showed in the cycle the address was presented. The two ports are independent. A read and a write to the same entry in the same cycle returns the old value. The new value is seen from the next cycle.
- R4: Register 0 of every thread always reads as zero, and a write to it has no effect.
- R5: With `mode`=0 (interleaved), `cur_tid` moves at each clock to the first thread whose stall bit is 0, searching `cur_tid+1`, `cur_tid+2` and onward modulo the thread count. The current thread is the last candidate.
- R6: With `mode`=1 (switch-on-stall), `cur_tid` holds while `stall[cur_tid]` is 0, whatever the other stall bits are. When `stall[cur_tid]` is 1, it moves to the first non-stalled thread in the same circular order as R5.
- R7: When all stall bits are 1, `cur_tid` holds and `idle` is 1 one clock later. Otherwise `idle` is 0 one clock later.
- R8: A change of `cur_tid` is a zero-cost switch. Reads presented in the very cycle after the switch already use the new thread's bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = interleave every cycle, 1 = switch on long stall |
| stall | input | NTHR | Per-thread stall flags, bit i for thread i |
| rd_addr_a | input | log2(NREG) | Register number, read port A |
| rd_addr_b | input | log2(NREG) | Register number, read port B |
| rd_data_a | output | DW | Read data, port A (one-cycle latency) |
| rd_data_b | output | DW | Read data, port B (one-cycle latency) |
| wr_en | input | 1 | Write enable |
| wr_tid | input | log2(NTHR) | Thread that owns the write |
| wr_addr | input | log2(NREG) | Register number written |
| wr_data | input | DW | Write data |
| cur_tid | output | log2(NTHR) | Active thread (registered) |
| idle | output | 1 | All threads were stalled last cycle (registered) |

## Verification
The bench targets writes aimed at a thread other than the active one. A design that wrote through the context pointer would put them in the wrong bank. It targets reads and writes that hit the same entry in one cycle, where forwarding would show the new value a cycle early, and writes to register 0, which a broken zero guard would leak. It covers stall patterns that leave only the current thread ready, or no thread at all, where a faulty round-robin would pick a stalled thread or wrap the wrong way. In switch-on-stall mode it stalls other threads while the current one stays ready, which a design that switched on any stall would get wrong. A reset in the middle of a run must return every bank to zero.

// File: rtl/ctxrf_pkg.sv
package ctxrf_pkg;
  // mode input encoding
  localparam logic MODE_FINE   = 1'b0;
  localparam logic MODE_COARSE = 1'b1;
  // number of read ports in the file
  localparam int NRD = 2;
endpackage

// File: rtl/ctxrf_sel.sv
module ctxrf_sel
  import ctxrf_pkg::*;
#(
  parameter int NTHR = 4,
  localparam int TW = $clog2(NTHR)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_i,
  input  logic [NTHR-1:0] stall_i,
  output logic [TW-1:0]   cur_o,
  output logic            idle_o
);

  logic [TW-1:0] cur_q, nxt;
  logic          idle_q;
  logic          all_stall;
  logic          found;

  assign all_stall = &stall_i;

  always_comb begin
    nxt   = cur_q;
    found = 1'b0;
    if (!(mode_i == MODE_COARSE && !stall_i[cur_q])) begin
      for (int k = 1; k <= NTHR; k++) begin
        if (!found && !stall_i[(int'(cur_q) + k) % NTHR]) begin
          found = 1'b1;
          nxt   = TW'((int'(cur_q) + k) % NTHR);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      idle_q <= 1'b0;
    end else begin
      cur_q  <= nxt;
      idle_q <= all_stall;
    end
  end

  assign cur_o  = cur_q;
  assign idle_o = idle_q;

  // checker state: stall flags seen one cycle earlier
  logic [NTHR-1:0] stall_d;
  always_ff @(posedge clk) begin
    if (rst) stall_d <= '1;
    else     stall_d <= stall_i;
  end

  p_coarse_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_COARSE && !stall_i[cur_q]) |=> (cur_q == $past(cur_q)));

  p_all_stall_r7: assert property (@(posedge clk) disable iff (rst)
    all_stall |=> (idle_o && cur_q == $past(cur_q)));

  p_pick_ready_r5: assert property (@(posedge clk) disable iff (rst)
    (!all_stall) |=> !stall_d[cur_q]);

endmodule

// File: rtl/ctxrf_bank.sv
module ctxrf_bank #(
  parameter int AW = 5,
  parameter int DW = 32,
  localparam int DEPTH = 2 ** AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  // simple dual-port RAM, registered read, old data on collision
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd_q <= mem[ra];
  end

  assign rd = rd_q;

endmodule

// File: rtl/ctxrf_vld.sv
module ctxrf_vld
  import ctxrf_pkg::*;
#(
  parameter int AW = 5,
  localparam int DEPTH = 2 ** AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [AW-1:0] ra [NRD],
  output logic          v  [NRD]
);

  logic [DEPTH-1:0] vld_q;
  logic             v_q [NRD];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (we) vld_q[wa] <= 1'b1;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) v_q[p] <= 1'b0;
      else     v_q[p] <= vld_q[ra[p]];
    end
    assign v[p] = v_q[p];
  end

  p_set_after_write_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> vld_q[$past(wa)]);

endmodule

// File: rtl/ctxrf_top.sv
module ctxrf_top
  import ctxrf_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int TW = $clog2(NTHR),
  localparam int RW = $clog2(NREG),
  localparam int AW = TW + RW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode,
  input  logic [NTHR-1:0] stall,
  input  logic [RW-1:0]   rd_addr_a,
  input  logic [RW-1:0]   rd_addr_b,
  output logic [DW-1:0]   rd_data_a,
  output logic [DW-1:0]   rd_data_b,
  input  logic            wr_en,
  input  logic [TW-1:0]   wr_tid,
  input  logic [RW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [TW-1:0]   cur_tid,
  output logic            idle
);

  logic [TW-1:0] tid;
  logic          we_eff;
  logic [AW-1:0] wa_phys;
  logic [AW-1:0] ra_phys [NRD];
  logic [RW-1:0] ra_reg  [NRD];
  logic [DW-1:0] ram_q   [NRD];
  logic          vld     [NRD];
  logic [DW-1:0] rdat    [NRD];

  ctxrf_sel #(.NTHR(NTHR)) u_sel (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode),
    .stall_i(stall),
    .cur_o  (tid),
    .idle_o (idle)
  );

  // register 0 is never written, so its valid bit stays clear
  assign we_eff  = wr_en && (wr_addr != '0);
  assign wa_phys = {wr_tid, wr_addr};
  assign ra_reg[0] = rd_addr_a;
  assign ra_reg[1] = rd_addr_b;

  ctxrf_vld #(.AW(AW)) u_vld (
    .clk(clk),
    .rst(rst),
    .we (we_eff),
    .wa (wa_phys),
    .ra (ra_phys),
    .v  (vld)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    assign ra_phys[p] = {tid, ra_reg[p]};
    ctxrf_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk(clk),
      .we (we_eff),
      .wa (wa_phys),
      .wd (wr_data),
      .ra (ra_phys[p]),
      .rd (ram_q[p])
    );
    assign rdat[p] = vld[p] ? ram_q[p] : '0;
  end

  assign rd_data_a = rdat[0];
  assign rd_data_b = rdat[1];
  assign cur_tid   = tid;

  p_zero_reg_a_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |=> (rd_data_a == '0));

  p_zero_reg_b_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == '0) |=> (rd_data_b == '0));

endmodule

// File: tb/sim_ctxrf_top.sv
`timescale 1ns/1ps
module sim_ctxrf_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        mode;
  logic [3:0]  stall;
  logic [2:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [31:0] rd_data_a, rd_data_b, wr_data;
  logic        wr_en;
  logic [1:0]  wr_tid, cur_tid;
  logic        idle;

  always #10 clk = ~clk;

  ctxrf_top u0 (
    .clk(clk), .rst(rst), .mode(mode), .stall(stall),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_tid(wr_tid), .wr_addr(wr_addr), .wr_data(wr_data),
    .cur_tid(cur_tid), .idle(idle)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [31:0] mdl [4][8];
  logic [1:0]  cur_m;

  // {mode, stall[3:0], ra, rb, we, wtid, wa, wd}
  localparam logic [48:0] VEC [16] = '{
    {1'b0, 4'h0, 3'd1, 3'd2, 1'b1, 2'd1, 3'd1, 32'h1111_0001},
    {1'b0, 4'h0, 3'd1, 3'd1, 1'b1, 2'd2, 3'd5, 32'h2222_0005},
    {1'b0, 4'h2, 3'd5, 3'd1, 1'b1, 2'd3, 3'd7, 32'h3333_0007},
    {1'b0, 4'h5, 3'd7, 3'd5, 1'b1, 2'd0, 3'd4, 32'h4444_0004},
    {1'b0, 4'h0, 3'd4, 3'd7, 1'b1, 2'd1, 3'd0, 32'hDEAD_0000},
    {1'b0, 4'h0, 3'd0, 3'd1, 1'b0, 2'd0, 3'd0, 32'h0},
    {1'b0, 4'h8, 3'd1, 3'd5, 1'b1, 2'd2, 3'd1, 32'h5555_0001},
    {1'b0, 4'hE, 3'd5, 3'd7, 1'b0, 2'd0, 3'd0, 32'h0},
    {1'b1, 4'h0, 3'd4, 3'd1, 1'b1, 2'd0, 3'd6, 32'h6666_0006},
    {1'b1, 4'h6, 3'd6, 3'd4, 1'b0, 2'd0, 3'd0, 32'h0},
    {1'b1, 4'h1, 3'd6, 3'd6, 1'b1, 2'd1, 3'd2, 32'h7777_0002},
    {1'b1, 4'h0, 3'd2, 3'd1, 1'b1, 2'd1, 3'd2, 32'h8888_0002},
    {1'b1, 4'h0, 3'd2, 3'd2, 1'b0, 2'd0, 3'd0, 32'h0},
    {1'b1, 4'hF, 3'd1, 3'd2, 1'b0, 2'd0, 3'd0, 32'h0},
    {1'b1, 4'h3, 3'd5, 3'd7, 1'b0, 2'd0, 3'd0, 32'h0},
    {1'b0, 4'h0, 3'd7, 3'd6, 1'b1, 2'd3, 3'd3, 32'h9999_0003}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 8; r++) mdl[t][r] = '0;
    cur_m = '0;
  endtask

  function automatic logic [1:0] next_tid(input logic md, input logic [3:0] st,
                                          input logic [1:0] c);
    logic [1:0] n;
    bit hit;
    n = c;
    hit = 0;
    if (md && !st[c]) return c;
    for (int k = 1; k <= 4; k++) begin
      if (!hit && !st[(int'(c) + k) % 4]) begin
        hit = 1;
        n = 2'((int'(c) + k) % 4);
      end
    end
    return n;
  endfunction

  // called at a negedge: drive, let one posedge pass, compare at next negedge
  task automatic step(input logic md, input logic [3:0] st, input logic [2:0] ra,
                      input logic [2:0] rb, input logic we, input logic [1:0] wt,
                      input logic [2:0] wa, input logic [31:0] wd, input string tag);
    logic [31:0] ea, eb;
    logic [1:0]  ec;
    mode = md; stall = st; rd_addr_a = ra; rd_addr_b = rb;
    wr_en = we; wr_tid = wt; wr_addr = wa; wr_data = wd;
    ea = (ra == 0) ? 32'h0 : mdl[cur_m][ra];
    eb = (rb == 0) ? 32'h0 : mdl[cur_m][rb];
    if (we && wa != 0) mdl[wt][wa] = wd;
    ec = next_tid(md, st, cur_m);
    cur_m = ec;
    @(negedge clk);
    chk({tag, " port A"}, rd_data_a, ea);
    chk({tag, " port B"}, rd_data_b, eb);
    chk({tag, " cur_tid"}, {30'h0, cur_tid}, {30'h0, ec});
    chk("R7 idle", {31'h0, idle}, {31'h0, &st});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    mode = 1'b1; stall = 4'h0; wr_en = 1'b0;
    rd_addr_a = 3'd1; rd_addr_b = 3'd7;
    wr_tid = 0; wr_addr = 0; wr_data = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset cur_tid", {30'h0, cur_tid}, 32'h0);
    chk("R1 reset idle", {31'h0, idle}, 32'h0);
    chk("R1 reset port A", rd_data_a, 32'h0);
    rst = 1'b0;
    clear_model();
  endtask

  // read every register of every thread, steering threads in coarse mode
  task automatic scan_all(input string tag);
    for (int t = 0; t < 4; t++) begin
      for (int r = 0; r < 8; r += 2)
        step(1'b1, 4'h0, 3'(r), 3'(r + 1), 1'b0, 2'd0, 3'd0, 32'h0, tag);
      step(1'b1, 4'h0 | (4'h1 << cur_m), 3'd0, 3'd0, 1'b0, 2'd0, 3'd0, 32'h0, "R6 steer");
    end
  endtask

  initial begin
    rst = 1'b1;
    do_reset();
    scan_all("R1 cleared");

    for (int i = 0; i < 16; i++)
      step(VEC[i][48], VEC[i][47:44], VEC[i][43:41], VEC[i][40:38], VEC[i][37],
           VEC[i][36:35], VEC[i][34:32], VEC[i][31:0], "R2 R3 R5 R6 table");

    // R2: write into non-active threads while coarse mode holds the current one
    for (int t = 0; t < 4; t++)
      step(1'b1, 4'hF ^ (4'h1 << cur_m), 3'd0, 3'd0, 1'b1, 2'(t), 3'd6,
           32'hA000_0000 + t, "R2 foreign write");
    scan_all("R2 R8 scan");

    // R3: same-entry collision, old value then new
    step(1'b1, 4'h0, 3'd3, 3'd3, 1'b1, cur_m, 3'd3, 32'hC0DE_0001, "R3 collide");
    step(1'b1, 4'h0, 3'd3, 3'd3, 1'b0, 2'd0, 3'd0, 32'h0, "R3 after");

    // R4: write to register 0 of the active thread
    step(1'b1, 4'h0, 3'd0, 3'd0, 1'b1, cur_m, 3'd0, 32'hFFFF_FFFF, "R4 zero write");
    step(1'b1, 4'h0, 3'd0, 3'd0, 1'b0, 2'd0, 3'd0, 32'h0, "R4 zero read");

    // R5: interleave with only the current thread ready, then with none
    step(1'b0, 4'hF ^ (4'h1 << cur_m), 3'd6, 3'd3, 1'b0, 2'd0, 3'd0, 32'h0, "R5 self only");
    step(1'b0, 4'hF, 3'd6, 3'd3, 1'b0, 2'd0, 3'd0, 32'h0, "R7 all stall");
    step(1'b0, 4'hF, 3'd6, 3'd3, 1'b0, 2'd0, 3'd0, 32'h0, "R7 all stall");
    for (int i = 0; i < 6; i++)
      step(1'b0, 4'h0, 3'd6, 3'd3, 1'b0, 2'd0, 3'd0, 32'h0, "R5 R8 rotate");

    // R1: reset in the middle of a run clears every bank
    do_reset();
    scan_all("R1 mid-run reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule